// File: doc/BRIEF.md
# UART Ping Command Bridge

This block sits between a UART byte receiver, a UART byte transmitter and a network interface of an on-chip mesh. It reads a byte stream from the receiver and recognises ping commands. A command begins with a node selector. The selector is either a single binary byte or a two-character ASCII sequence. A fixed-length payload follows the selector. For each complete command, the block raises one request toward the network interface carrying the target node and the payload.

When the network interface later hands back the echoed packet together with its measured round-trip latency, the block serialises a reply one byte at a time toward the transmitter. The reply format follows the mode of the most recently issued command. A binary command gets a compact binary record. An ASCII command gets a readable text line.

A selector or digit that names no valid node is dropped, and the parser goes back to waiting for a selector. A command that stalls for longer than a programmable number of idle cycles is discarded. Out-of-range latencies are saturated so that each reply keeps its fixed length.

Top module: `uart_ping_bridge`

## Requirements
- R1: A byte whose upper nibble is 0xA and whose lower nibble i is below NODES (4) starts a binary-mode command for node i.
- R2: The character 'S' (0x53) or 's' (0x73), followed by a character '0'..'3' (0x30 + i), starts an ASCII-mode command for node i.
- R3: The PLEN (5) bytes after the selector form the payload. The first byte lands in req_payload[39:32] and the last in [7:0]. The request holds node and payload stable until req_ready. While it waits, rx_ready is low.
- R4: Any other byte while idle is ignored. A non-digit or out-of-range digit after 'S'/'s' returns the parser to idle. No request results in either case.
- R5: After a selector, if tmo_limit consecutive cycles pass with no received byte, the partial command is discarded and its later bytes are treated as idle-state bytes.
- R6: A binary reply is 8 bytes: 0xB0 | node, the five payload bytes first to last, then the 16-bit latency most significant byte first.
- R7: An ASCII reply is the text "[Node i] PPPPP L: NNNN cycles" followed by CR (0x0D) and LF (0x0A), 31 bytes, with NNNN as four decimal digits with leading zeros.
- R8: A latency above 65535 is sent as 0xFFFF in a binary reply. A latency above 9999 is printed as 9999 in an ASCII reply.
- R9: The reply mode is the mode of the most recent command whose request was accepted.
- R10: Reply bytes are offered one at a time. tx_data stays stable while tx_valid is high and tx_ready is low. rsp_ready is low while a reply is being sent.
- R11: During and right after reset, rx_ready and rsp_ready are high, and req_valid and tx_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tmo_limit | input | 16 | Idle cycles allowed between command bytes |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block takes the received byte |
| req_valid | output | 1 | Ping request pending |
| req_ready | input | 1 | Network interface accepts the request |
| req_node | output | 2 | Target node of the request |
| req_payload | output | 40 | Payload, first byte most significant |
| rsp_valid | input | 1 | Echoed packet available |
| rsp_ready | output | 1 | Block takes the echoed packet |
| rsp_node | input | 2 | Node that echoed the packet |
| rsp_payload | input | 40 | Echoed payload |
| rsp_latency | input | 20 | Measured latency in cycles |
| tx_valid | output | 1 | Reply byte available |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmitter takes the reply byte |

## Verification
The bench targets four kinds of corner case.

Latencies of exactly 9999, above 9999 and above 65535 probe the saturation logic. A design that truncated the value instead of clamping it would print wrapped digits or low-order bytes.

An ASCII command followed by a binary one, with a single reply, shows whether the reply mode follows the latest accepted request rather than the first. Invalid selectors, an out-of-range digit and an abandoned command stalled past the timeout must all leave req_valid low. A parser that failed to return to idle would instead swallow the later bytes into a bogus request.

A transmitter that stalls every third cycle catches a design that advances its byte pointer without a handshake. Such a design would drop or repeat bytes.

// File: rtl/uart_ping_pkg.sv
package uart_ping_pkg;

  typedef enum logic [1:0] {
    P_IDLE  = 2'd0,
    P_DIGIT = 2'd1,
    P_BODY  = 2'd2,
    P_ISSUE = 2'd3
  } parse_state_e;

  localparam logic [7:0] CH_UPPER_S = 8'h53;
  localparam logic [7:0] CH_LOWER_S = 8'h73;
  localparam logic [7:0] CH_ZERO    = 8'h30;
  localparam logic [3:0] BIN_SEL_HI = 4'hA;
  localparam logic [3:0] BIN_RSP_HI = 4'hB;

endpackage

// File: rtl/ping_cmd_parser.sv
module ping_cmd_parser
  import uart_ping_pkg::*;
#(
  parameter int NODE_W = 2,
  parameter int PLEN   = 5,
  parameter int TMO_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TMO_W-1:0]     tmo_limit,
  input  logic                 rx_valid,
  input  logic [7:0]           rx_data,
  output logic                 rx_ready,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [NODE_W-1:0]    req_node,
  output logic                 req_ascii,
  output logic [8*PLEN-1:0]    req_payload
);

  localparam int NODES = 1 << NODE_W;
  localparam int PW    = 8 * PLEN;
  localparam int BC_W  = $clog2(PLEN + 1);

  parse_state_e        state_q, state_d;
  logic [NODE_W-1:0]   node_q, node_d;
  logic                ascii_q, ascii_d;
  logic [PW-1:0]       pay_q, pay_d;
  logic [BC_W-1:0]     bcnt_q, bcnt_d;
  logic [TMO_W-1:0]    idle_q, idle_d;

  logic rx_fire;
  logic is_bin_sel;
  logic is_letter;
  logic is_digit;

  assign rx_ready  = (state_q != P_ISSUE);
  assign rx_fire   = rx_valid && rx_ready;
  assign req_valid = (state_q == P_ISSUE);
  assign req_node  = node_q;
  assign req_ascii = ascii_q;
  assign req_payload = pay_q;

  assign is_bin_sel = (rx_data[7:4] == BIN_SEL_HI) && (int'(rx_data[3:0]) < NODES);
  assign is_letter  = (rx_data == CH_UPPER_S) || (rx_data == CH_LOWER_S);
  assign is_digit   = (rx_data >= CH_ZERO) && (int'(rx_data) < int'(CH_ZERO) + NODES);

  // next-state logic
  always_comb begin
    state_d = state_q;
    node_d  = node_q;
    ascii_d = ascii_q;
    pay_d   = pay_q;
    bcnt_d  = bcnt_q;
    idle_d  = idle_q;

    unique case (state_q)
      P_IDLE: begin
        idle_d = '0;
        bcnt_d = '0;
        if (rx_fire) begin
          if (is_bin_sel) begin
            node_d  = rx_data[NODE_W-1:0];
            ascii_d = 1'b0;
            state_d = P_BODY;
          end else if (is_letter) begin
            state_d = P_DIGIT;
          end
        end
      end
      P_DIGIT, P_BODY: begin
        if (rx_fire) begin
          idle_d = '0;
          if (state_q == P_DIGIT) begin
            if (is_digit) begin
              node_d  = NODE_W'(rx_data - CH_ZERO);
              ascii_d = 1'b1;
              state_d = P_BODY;
            end else begin
              state_d = P_IDLE;
            end
          end else begin
            pay_d  = {pay_q[PW-9:0], rx_data};
            bcnt_d = bcnt_q + 1'b1;
            if (int'(bcnt_q) == PLEN - 1) state_d = P_ISSUE;
          end
        end else if (idle_q == tmo_limit) begin
          state_d = P_IDLE;
        end else begin
          idle_d = idle_q + 1'b1;
        end
      end
      P_ISSUE: begin
        if (req_ready) state_d = P_IDLE;
      end
      default: state_d = P_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= P_IDLE;
      node_q  <= '0;
      ascii_q <= 1'b0;
      pay_q   <= '0;
      bcnt_q  <= '0;
      idle_q  <= '0;
    end else begin
      state_q <= state_d;
      node_q  <= node_d;
      ascii_q <= ascii_d;
      pay_q   <= pay_d;
      bcnt_q  <= bcnt_d;
      idle_q  <= idle_d;
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_payload) && $stable(req_node));

  // R3
  rx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !rx_ready);

  // R5
  idle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == P_BODY) && !rx_valid && (idle_q == tmo_limit) |=> (state_q == P_IDLE));

endmodule

// File: rtl/ping_dec4.sv
module ping_dec4 #(
  parameter int BIN_W = 14
) (
  input  logic [BIN_W-1:0] value,
  output logic [15:0]      bcd
);

  localparam int ACC_W = 16 + BIN_W;

  logic [ACC_W-1:0] acc;

  always_comb begin
    acc = '0;
    acc[BIN_W-1:0] = value;
    for (int b = 0; b < BIN_W; b++) begin
      for (int d = 0; d < 4; d++) begin
        if (acc[BIN_W + 4*d +: 4] >= 4'd5)
          acc[BIN_W + 4*d +: 4] = acc[BIN_W + 4*d +: 4] + 4'd3;
      end
      acc = acc << 1;
    end
    bcd = acc[ACC_W-1 -: 16];
  end

endmodule

// File: rtl/ping_reply_fmt.sv
module ping_reply_fmt
  import uart_ping_pkg::*;
#(
  parameter int NODE_W = 2,
  parameter int PLEN   = 5,
  parameter int LAT_W  = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_fire,
  input  logic                 cmd_ascii,
  input  logic                 rsp_valid,
  output logic                 rsp_ready,
  input  logic [NODE_W-1:0]    rsp_node,
  input  logic [8*PLEN-1:0]    rsp_payload,
  input  logic [LAT_W-1:0]     rsp_latency,
  output logic                 tx_valid,
  output logic [7:0]           tx_data,
  input  logic                 tx_ready
);

  localparam int PW    = 8 * PLEN;
  localparam int B_LEN = PLEN + 3;
  localparam int A_NOD = 6;
  localparam int A_PAY = A_NOD + 3;
  localparam int A_MID = A_PAY + PLEN;
  localparam int A_LAT = A_MID + 4;
  localparam int A_TAIL = A_LAT + 4;
  localparam int A_LEN = A_TAIL + 9;
  localparam int IDX_W = $clog2(A_LEN + 1);

  localparam logic [47:0] HEAD = "[Node ";
  localparam logic [31:0] MID  = " L: ";
  localparam logic [71:0] TAIL = {" cycles", 8'h0D, 8'h0A};

  logic                mode_q, mode_d;
  logic                busy_q, busy_d;
  logic                amode_q, amode_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [NODE_W-1:0]   node_q, node_d;
  logic [PW-1:0]       pay_q, pay_d;
  logic [15:0]         lbin_q, lbin_d;
  logic [13:0]         ldec_q, ldec_d;
  logic [15:0]         bcd;
  logic                rsp_fire;
  logic                tx_fire;
  logic                last_byte;

  ping_dec4 #(.BIN_W(14)) dec_i (
    .value (ldec_q),
    .bcd   (bcd)
  );

  assign rsp_ready = !busy_q;
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign tx_valid  = busy_q;
  assign tx_fire   = tx_valid && tx_ready;
  assign last_byte = amode_q ? (int'(idx_q) == A_LEN - 1) : (int'(idx_q) == B_LEN - 1);

  // byte selection
  always_comb begin
    int k;
    k = int'(idx_q);
    tx_data = 8'h00;
    if (!amode_q) begin
      if (k == 0)              tx_data = {BIN_RSP_HI, 4'(node_q)};
      else if (k <= PLEN)      tx_data = pay_q[(PLEN-k)*8 +: 8];
      else if (k == PLEN + 1)  tx_data = lbin_q[15:8];
      else                     tx_data = lbin_q[7:0];
    end else begin
      if (k < A_NOD)           tx_data = HEAD[(A_NOD-1-k)*8 +: 8];
      else if (k == A_NOD)     tx_data = CH_ZERO + 8'(node_q);
      else if (k == A_NOD + 1) tx_data = 8'h5D;
      else if (k == A_NOD + 2) tx_data = 8'h20;
      else if (k < A_MID)      tx_data = pay_q[(PLEN-1-(k-A_PAY))*8 +: 8];
      else if (k < A_LAT)      tx_data = MID[(3-(k-A_MID))*8 +: 8];
      else if (k < A_TAIL)     tx_data = CH_ZERO + {4'h0, bcd[(3-(k-A_LAT))*4 +: 4]};
      else                     tx_data = TAIL[(8-(k-A_TAIL))*8 +: 8];
    end
  end

  // next-state logic
  always_comb begin
    mode_d  = mode_q;
    busy_d  = busy_q;
    amode_d = amode_q;
    idx_d   = idx_q;
    node_d  = node_q;
    pay_d   = pay_q;
    lbin_d  = lbin_q;
    ldec_d  = ldec_q;
    if (cmd_fire) mode_d = cmd_ascii;
    if (rsp_fire) begin
      busy_d  = 1'b1;
      amode_d = mode_q;
      idx_d   = '0;
      node_d  = rsp_node;
      pay_d   = rsp_payload;
      lbin_d  = (rsp_latency > LAT_W'(65535)) ? 16'hFFFF : 16'(rsp_latency);
      ldec_d  = (rsp_latency > LAT_W'(9999))  ? 14'd9999 : 14'(rsp_latency);
    end else if (tx_fire) begin
      if (last_byte) busy_d = 1'b0;
      else           idx_d  = idx_q + 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      busy_q  <= 1'b0;
      amode_q <= 1'b0;
      idx_q   <= '0;
      node_q  <= '0;
      pay_q   <= '0;
      lbin_q  <= '0;
      ldec_q  <= '0;
    end else begin
      mode_q  <= mode_d;
      busy_q  <= busy_d;
      amode_q <= amode_d;
      idx_q   <= idx_d;
      node_q  <= node_d;
      pay_q   <= pay_d;
      lbin_q  <= lbin_d;
      ldec_q  <= ldec_d;
    end
  end

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R10
  rsp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rsp_ready);

  // R8
  dec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (bcd[15:12] <= 4'd9) && (bcd[11:8] <= 4'd9) && (bcd[7:4] <= 4'd9) && (bcd[3:0] <= 4'd9));

endmodule

// File: rtl/uart_ping_bridge.sv
module uart_ping_bridge #(
  parameter int NODE_W = 2,
  parameter int PLEN   = 5,
  parameter int TMO_W  = 16,
  parameter int LAT_W  = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TMO_W-1:0]     tmo_limit,
  input  logic                 rx_valid,
  input  logic [7:0]           rx_data,
  output logic                 rx_ready,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [NODE_W-1:0]    req_node,
  output logic [8*PLEN-1:0]    req_payload,
  input  logic                 rsp_valid,
  output logic                 rsp_ready,
  input  logic [NODE_W-1:0]    rsp_node,
  input  logic [8*PLEN-1:0]    rsp_payload,
  input  logic [LAT_W-1:0]     rsp_latency,
  output logic                 tx_valid,
  output logic [7:0]           tx_data,
  input  logic                 tx_ready
);

  logic [1:0] rst_sync_q;
  logic       srst_n;
  logic       req_ascii;
  logic       cmd_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  assign cmd_fire = req_valid && req_ready;

  ping_cmd_parser #(.NODE_W(NODE_W), .PLEN(PLEN), .TMO_W(TMO_W)) parse_i (
    .clk         (clk),
    .rst_n       (srst_n),
    .tmo_limit   (tmo_limit),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .rx_ready    (rx_ready),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_node    (req_node),
    .req_ascii   (req_ascii),
    .req_payload (req_payload)
  );

  ping_reply_fmt #(.NODE_W(NODE_W), .PLEN(PLEN), .LAT_W(LAT_W)) fmt_i (
    .clk         (clk),
    .rst_n       (srst_n),
    .cmd_fire    (cmd_fire),
    .cmd_ascii   (req_ascii),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_node    (rsp_node),
    .rsp_payload (rsp_payload),
    .rsp_latency (rsp_latency),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .tx_ready    (tx_ready)
  );

endmodule

// File: tb/uart_ping_bridge_tb.sv
module uart_ping_bridge_tb_top;

  typedef struct packed {
    logic [7:0]  s0;
    logic [7:0]  s1;
    logic        two;
    logic [39:0] pay;
    logic [1:0]  node;
    logic        ascii;
    logic [19:0] lat;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'hA1, 8'h00, 1'b0, "HELLO", 2'd1, 1'b0, 20'd5},
    '{8'h53, 8'h32, 1'b1, "ABCDE", 2'd2, 1'b1, 20'd123},
    '{8'h73, 8'h30, 1'b1, "xyz12", 2'd0, 1'b1, 20'd12000},
    '{8'hA3, 8'h00, 1'b0, "QRSTU", 2'd3, 1'b0, 20'd70000},
    '{8'hA0, 8'h00, 1'b0, "ping!", 2'd0, 1'b0, 20'd9999},
    '{8'h73, 8'h33, 1'b1, "zzzzz", 2'd3, 1'b1, 20'd0}
  };

  logic        clk;
  logic        rst_n;
  logic [15:0] tmo_limit;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_ready;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_node;
  logic [39:0] req_payload;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [1:0]  rsp_node;
  logic [39:0] rsp_payload;
  logic [19:0] rsp_latency;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic mon_on = 1'b0;
  logic stall_q = 1'b0;
  logic [7:0] data_q = 8'h00;
  logic [7:0] rbuf [40];
  int rlen;

  uart_ping_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .req_valid(req_valid), .req_ready(req_ready), .req_node(req_node), .req_payload(req_payload),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_node(rsp_node), .rsp_payload(rsp_payload),
    .rsp_latency(rsp_latency),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // R10 monitor: hold during stall, no response intake while replying
  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      if (stall_q) chk(tx_valid && tx_data == data_q, "R10 tx hold", {55'd0, tx_valid, tx_data}, {56'd1, data_q});
      if (tx_valid && rsp_ready) chk(1'b0, "R10 rsp_ready while replying", 64'd1, 64'd0);
      stall_q = tx_valid && !tx_ready;
      data_q  = tx_data;
    end
  end

  function automatic string exp_reply(input logic ascii, input logic [1:0] node,
                                      input logic [39:0] pay, input logic [19:0] lat);
    string s;
    int v;
    if (ascii) begin
      v = (lat > 20'd9999) ? 9999 : int'(lat);
      s = $sformatf("[Node %0d] %c%c%c%c%c L: %04d cycles%c%c", node,
                    pay[39:32], pay[31:24], pay[23:16], pay[15:8], pay[7:0], v, 8'h0D, 8'h0A);
    end else begin
      v = (lat > 20'd65535) ? 65535 : int'(lat);
      s = $sformatf("%c%c%c%c%c%c%c%c", {4'hB, 2'b00, node}, pay[39:32], pay[31:24],
                    pay[23:16], pay[15:8], pay[7:0], v[15:8], v[7:0]);
    end
    return s;
  endfunction

  task automatic send_byte(input logic [7:0] b);
    int w;
    w = 0;
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    while (!rx_ready && w < 200) begin
      @(negedge clk);
      w++;
    end
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_cmd(input vec_t v);
    send_byte(v.s0);
    if (v.two) send_byte(v.s1);
    for (int k = 0; k < 5; k++) send_byte(v.pay[39-8*k -: 8]);
  endtask

  task automatic take_req(input logic [1:0] node, input logic [39:0] pay, input int hold, input string tag);
    int w;
    w = 0;
    while (!req_valid && w < 100) begin
      @(negedge clk);
      w++;
    end
    chk(req_valid, {tag, " req_valid"}, {63'd0, req_valid}, 64'd1);
    chk(req_node == node && req_payload == pay, {tag, " req fields"},
        {22'd0, req_node, req_payload}, {22'd0, node, pay});
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(req_valid && !rx_ready && req_payload == pay, "R3 hold while waiting",
          {22'd0, req_valid, rx_ready, req_payload}, {22'd0, 2'b10, pay});
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  task automatic give_rsp(input logic [1:0] node, input logic [39:0] pay, input logic [19:0] lat);
    @(negedge clk);
    rsp_valid = 1'b1;
    rsp_node = node;
    rsp_payload = pay;
    rsp_latency = lat;
    while (!rsp_ready) @(negedge clk);
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic get_reply(input int want);
    int w;
    w = 0;
    rlen = 0;
    while (rlen < want && w < 600) begin
      tx_ready = (w % 3) != 2;
      if (tx_valid && tx_ready) begin
        rbuf[rlen] = tx_data;
        rlen++;
      end
      @(negedge clk);
      w++;
    end
    tx_ready = 1'b0;
  endtask

  task automatic check_reply(input string exp, input string tag);
    int bad;
    bad = -1;
    for (int k = 0; k < exp.len(); k++)
      if (bad < 0 && (k >= rlen || rbuf[k] != exp[k])) bad = k;
    if (bad < 0) chk(rlen == exp.len(), {tag, " reply length"}, 64'(rlen), 64'(exp.len()));
    else chk(1'b0, $sformatf("%s reply byte %0d", tag, bad),
             (bad < rlen) ? 64'(rbuf[bad]) : 64'hFFFF, 64'(exp[bad]));
  endtask

  task automatic watch_no_req(input int n, input string tag);
    logic seen;
    seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (req_valid) seen = 1'b1;
    end
    chk(!seen, tag, {63'd0, seen}, 64'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    tmo_limit = 16'd20;
    rx_valid = 1'b0; rx_data = 8'h00;
    req_ready = 1'b0;
    rsp_valid = 1'b0; rsp_node = 2'd0; rsp_payload = '0; rsp_latency = '0;
    tx_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R11 during reset
    chk(rx_ready && rsp_ready && !req_valid && !tx_valid, "R11 in reset",
        {60'd0, rx_ready, rsp_ready, req_valid, tx_valid}, {60'd0, 4'b1100});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rx_ready && rsp_ready && !req_valid && !tx_valid, "R11 after release",
        {60'd0, rx_ready, rsp_ready, req_valid, tx_valid}, {60'd0, 4'b1100});
    mon_on = 1'b1;

    // vector table: R1 R2 R3 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      send_cmd(VECS[i]);
      take_req(VECS[i].node, VECS[i].pay, (i == 0) ? 4 : 0,
               VECS[i].ascii ? "R2" : "R1");
      give_rsp(VECS[i].node, VECS[i].pay, VECS[i].lat);
      get_reply(VECS[i].ascii ? 31 : 8);
      check_reply(exp_reply(VECS[i].ascii, VECS[i].node, VECS[i].pay, VECS[i].lat),
                  VECS[i].ascii ? $sformatf("R7 R8 vec%0d", i) : $sformatf("R6 R8 vec%0d", i));
    end

    // R4: bad digit, invalid binary node, stray bytes
    send_byte(8'h53); send_byte(8'h39);
    send_byte(8'hA7);
    for (int k = 0; k < 5; k++) send_byte(8'h41 + 8'(k));
    watch_no_req(20, "R4 invalid selectors ignored");
    send_byte(8'hA2);
    for (int k = 0; k < 5; k++) send_byte(8'h61 + 8'(k));
    take_req(2'd2, "abcde", 0, "R4 recovery");

    // R5: abandoned command after timeout
    send_byte(8'hA1); send_byte(8'h61); send_byte(8'h62);
    repeat (60) @(negedge clk);
    send_byte(8'h63); send_byte(8'h64); send_byte(8'h65);
    watch_no_req(20, "R5 stale command discarded");
    // R5: slow but within limit
    send_byte(8'h73); repeat (10) @(negedge clk);
    send_byte(8'h31);
    for (int k = 0; k < 5; k++) begin
      repeat (10) @(negedge clk);
      send_byte(8'h6B + 8'(k));
    end
    take_req(2'd1, "klmno", 0, "R5 slow command kept");

    // R9: ascii then binary request, reply follows the binary one
    send_cmd('{8'h53, 8'h31, 1'b1, "MODE1", 2'd1, 1'b1, 20'd0});
    take_req(2'd1, "MODE1", 0, "R9 first");
    send_cmd('{8'hA2, 8'h00, 1'b0, "MODE2", 2'd2, 1'b0, 20'd0});
    take_req(2'd2, "MODE2", 0, "R9 second");
    give_rsp(2'd2, "MODE2", 20'd7);
    get_reply(8);
    check_reply(exp_reply(1'b0, 2'd2, "MODE2", 20'd7), "R9 mode follows latest");

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule